// File: doc/BRIEF.md
# Write-Through Store Drain Buffer

This block sits between a write-through data cache and a slower main memory. Every store the processor makes is written into the cache and also handed to this buffer, so cache lines never hold data that memory lacks and no line needs a dirty flag. The buffer holds up to a small number of pending word writes and sends them to memory one at a time, oldest first. It uses a request/acknowledge handshake on the memory side, so the processor never waits out the memory write latency itself.

The processor side is held off only when a new store arrives and every slot is taken. A slot freed by a memory acknowledge in that same cycle counts as free. A lookup port lets the cache controller, on a read miss, ask whether the missing word still sits in the buffer. If it does, the buffer returns the most recent pending value for that address, so a read never sees stale memory contents. A busy flag stays high while any write is pending, so a flush or fence can wait until memory is fully up to date.

Top module: `store_drain_buffer`

## Requirements
- R1: A store accepted while the buffer is empty appears on the memory port in the next cycle: `mem_req` is 1, and `mem_addr` and `mem_data` carry the store's address and data.
- R2: Pending stores leave in arrival order. Exactly one entry retires for each cycle in which `mem_req` and `mem_ack` are both 1. While `mem_req` is 1 and `mem_ack` is 0, the head address and data do not change.
- R3: `st_stall` is 1 in the same cycle exactly when `st_valid` is 1, all DEPTH slots are occupied, and no retirement happens in that cycle. A stalled store is not stored.
- R4: When the buffer is full and an acknowledge retires the head in the same cycle as a new store, the store is accepted without a stall and joins the tail.
- R5: The address on `lk_addr` in cycle t is compared with every pending entry in cycle t. The result appears on `lk_hit` and `lk_data` in cycle t+1. On no match, `lk_hit` is 0 and `lk_data` is 0.
- R6: When several pending entries match, `lk_data` returns the data of the most recently accepted one.
- R7: A store accepted in the same cycle as the lookup counts as the youngest entry for that lookup.
- R8: `busy` is 1 in every cycle after a cycle in which an entry is pending or being accepted. It drops to 0 in the cycle after the last entry retires.
- R9: `mem_ack` while `mem_req` is 0 has no effect: the buffer stays empty, and the next store drains normally.
- R10: After reset the buffer is empty, and `busy`, `mem_req`, `lk_hit` and `st_stall` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Cache side presents a store this cycle |
| st_addr | input | ADDR_W | Word address of the store |
| st_data | input | DATA_W | Store data |
| st_stall | output | 1 | Store not taken this cycle, hold it |
| mem_req | output | 1 | Head entry waiting for memory |
| mem_addr | output | ADDR_W | Head entry address |
| mem_data | output | DATA_W | Head entry data |
| mem_ack | input | 1 | Memory took the head entry this cycle |
| lk_addr | input | ADDR_W | Read-miss address to search for |
| lk_hit | output | 1 | A pending entry matched (one cycle later) |
| lk_data | output | DATA_W | Youngest matching data, 0 on miss |
| busy | output | 1 | Some write still pending |

## Verification
`st_stall` is a same-cycle result. It is sampled one time unit after the inputs change and before the next rising edge. `mem_req`, the head fields and `busy` change one edge after the store or acknowledge that causes them. `lk_hit` and `lk_data` appear one edge after the lookup address is presented. The bench drives inputs just after a rising edge and reads these registered results just after the following edge. Stalled stores and stray acknowledges are checked by draining the buffer and comparing the exact sequence of entries at the memory port, including its final empty state.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int unsigned WB_ADDR_W = 32;
  localparam int unsigned WB_DATA_W = 32;
  localparam int unsigned WB_DEPTH  = 4;
endpackage

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             st_valid,
  input  logic             mem_ack,
  output logic             push,
  output logic             pop,
  output logic             stall,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [LVL_W-1:0] level,
  output logic             busy
);
  logic             full;
  logic [LVL_W-1:0] level_n;

  assign full  = (level == LVL_W'(DEPTH));
  assign pop   = (level != '0) && mem_ack;
  assign stall = st_valid && full && !pop;
  assign push  = st_valid && !stall;

  always_comb begin
    level_n = level;
    if (push && !pop) level_n = level + LVL_W'(1);
    else if (pop && !push) level_n = level - LVL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      busy   <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
      level <= level_n;
      busy  <= (level_n != '0);
    end
  end
endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [PTR_W-1:0]             waddr,
  input  logic [ADDR_W-1:0]            wa,
  input  logic [DATA_W-1:0]            wd,
  output logic [DEPTH-1:0][ADDR_W-1:0] addr_q,
  output logic [DEPTH-1:0][DATA_W-1:0] data_q
);
  // No reset on the payload: occupancy comes from the controller.
  always_ff @(posedge clk) begin
    if (we) begin
      addr_q[waddr] <= wa;
      data_q[waddr] <= wd;
    end
  end
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = PTR_W + 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [DEPTH-1:0][ADDR_W-1:0] addr_q,
  input  logic [DEPTH-1:0][DATA_W-1:0] data_q,
  input  logic [PTR_W-1:0]             rd_ptr,
  input  logic [LVL_W-1:0]             level,
  input  logic                         push,
  input  logic [ADDR_W-1:0]            st_addr,
  input  logic [DATA_W-1:0]            st_data,
  input  logic [ADDR_W-1:0]            lk_addr,
  output logic                         lk_hit,
  output logic [DATA_W-1:0]            lk_data
);
  logic              hit_n;
  logic [DATA_W-1:0] data_n;
  logic [PTR_W-1:0]  idx;

  // Scan oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    hit_n  = 1'b0;
    data_n = '0;
    idx    = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = rd_ptr + PTR_W'(k);
      if ((LVL_W'(k) < level) && (addr_q[idx] == lk_addr)) begin
        hit_n  = 1'b1;
        data_n = data_q[idx];
      end
    end
    if (push && (st_addr == lk_addr)) begin
      hit_n  = 1'b1;
      data_n = st_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit  <= 1'b0;
      lk_data <= '0;
    end else begin
      lk_hit  <= hit_n;
      lk_data <= data_n;
    end
  end
endmodule

// File: rtl/store_drain_buffer.sv
module store_drain_buffer
  import wbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = WB_ADDR_W,
  parameter int unsigned DATA_W = WB_DATA_W,
  parameter int unsigned DEPTH  = WB_DEPTH,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_stall,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  output logic              busy
);
  logic                         push, pop;
  logic [PTR_W-1:0]             wr_ptr, rd_ptr;
  logic [LVL_W-1:0]             level;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic [DEPTH-1:0][DATA_W-1:0] data_q;

  wbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .st_valid(st_valid), .mem_ack(mem_ack),
    .push(push), .pop(pop), .stall(st_stall),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(level), .busy(busy)
  );

  wbuf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(push), .waddr(wr_ptr), .wa(st_addr), .wd(st_data),
    .addr_q(addr_q), .data_q(data_q)
  );

  wbuf_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_match (
    .clk(clk), .rst(rst), .addr_q(addr_q), .data_q(data_q),
    .rd_ptr(rd_ptr), .level(level), .push(push),
    .st_addr(st_addr), .st_data(st_data), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_data(lk_data)
  );

  assign mem_req  = (level != '0);
  assign mem_addr = addr_q[rd_ptr];
  assign mem_data = data_q[rd_ptr];
endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned LVL_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              st_valid,
  input logic              st_stall,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              mem_ack,
  input logic              busy,
  input logic [LVL_W-1:0]  level
);
  // R3: a stall only with a store pending and every slot full
  a_r3_stall_needs_full: assert property (@(posedge clk) disable iff (rst)
    st_stall |-> (st_valid && level == LVL_W'(DEPTH)));

  // R4: a retirement in the same cycle always frees room
  a_r4_no_stall_on_drain: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |-> !st_stall);

  // R1: an accepted store is at memory in the next cycle
  a_r1_req_after_accept: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_stall) |=> mem_req);

  // R2: head held steady until acknowledged
  a_r2_head_stable: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));

  // R8: busy drops only after an acknowledge
  a_r8_busy_falls_on_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(mem_ack));

  // R9: a stray acknowledge leaves an empty buffer empty
  a_r9_stray_ack: assert property (@(posedge clk) disable iff (rst)
    (!mem_req && mem_ack && !st_valid) |=> (level == '0));

  // R2: occupancy never exceeds the slot count
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));
endmodule

bind store_drain_buffer wbuf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .st_valid(st_valid), .st_stall(st_stall),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
  .mem_ack(mem_ack), .busy(busy), .level(level)
);

// File: tb/store_drain_buffer_bench.sv
`timescale 1ns/1ps
module store_drain_buffer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic        st_stall;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_data;
  logic        mem_ack = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_hit;
  logic [31:0] lk_data;
  logic        busy;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  store_drain_buffer u_store_drain_buffer (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_stall(st_stall), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data), .busy(busy)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Store with no acknowledge; expects acceptance.
  task automatic put(input logic [31:0] a, input logic [31:0] d);
    st_valid = 1'b1; st_addr = a; st_data = d;
    #1;
    chk(st_stall == 1'b0, "R3 no stall below full", 32'(st_stall), 32'd0);
    tick();
    st_valid = 1'b0;
  endtask

  // Check head, busy, then acknowledge it.
  task automatic take(input logic [31:0] a, input logic [31:0] d, input string tag);
    chk(mem_req == 1'b1, {tag, " req"}, 32'(mem_req), 32'd1);
    chk(mem_addr == a, {tag, " addr"}, mem_addr, a);
    chk(mem_data == d, {tag, " data"}, mem_data, d);
    chk(busy == 1'b1, "R8 busy while pending", 32'(busy), 32'd1);
    mem_ack = 1'b1;
    tick();
    mem_ack = 1'b0;
  endtask

  task automatic expect_empty(input string tag);
    chk(mem_req == 1'b0, {tag, " req low"}, 32'(mem_req), 32'd0);
    chk(busy == 1'b0, {tag, " busy low"}, 32'(busy), 32'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    chk(busy == 1'b0, "R10 busy", 32'(busy), 32'd0);
    chk(mem_req == 1'b0, "R10 mem_req", 32'(mem_req), 32'd0);
    chk(lk_hit == 1'b0, "R10 lk_hit", 32'(lk_hit), 32'd0);
    chk(st_stall == 1'b0, "R10 st_stall", 32'(st_stall), 32'd0);
  endtask

  task automatic t_single();
    put(32'h100, 32'hA5A5_0001);
    take(32'h100, 32'hA5A5_0001, "R1 first store");
    expect_empty("R8 after last ack");
  endtask

  task automatic t_full_stall();
    for (int i = 0; i < 4; i++) put(32'h200 + 32'(i), 32'hB000 + 32'(i));
    st_valid = 1'b1; st_addr = 32'h299; st_data = 32'hDEAD;
    #1;
    chk(st_stall == 1'b1, "R3 stall when full", 32'(st_stall), 32'd1);
    tick();
    st_valid = 1'b0;
    chk(mem_addr == 32'h200, "R2 head stable", mem_addr, 32'h200);
    for (int i = 0; i < 4; i++) take(32'h200 + 32'(i), 32'hB000 + 32'(i), "R2 order");
    expect_empty("R3 stalled store dropped");
  endtask

  task automatic t_full_drain();
    for (int i = 0; i < 4; i++) put(32'h300 + 32'(i), 32'hC000 + 32'(i));
    st_valid = 1'b1; st_addr = 32'h304; st_data = 32'hC004;
    mem_ack = 1'b1;
    #1;
    chk(st_stall == 1'b0, "R4 no stall with drain", 32'(st_stall), 32'd0);
    tick();
    st_valid = 1'b0; mem_ack = 1'b0;
    for (int i = 1; i < 5; i++) take(32'h300 + 32'(i), 32'hC000 + 32'(i), "R4 order");
    expect_empty("R4 drained");
  endtask

  task automatic t_lookup();
    put(32'h40, 32'd1);
    put(32'h44, 32'd2);
    put(32'h40, 32'd3);
    lk_addr = 32'h40; tick();
    chk(lk_hit == 1'b1, "R6 hit", 32'(lk_hit), 32'd1);
    chk(lk_data == 32'd3, "R6 youngest data", lk_data, 32'd3);
    lk_addr = 32'h48; tick();
    chk(lk_hit == 1'b0, "R5 miss hit", 32'(lk_hit), 32'd0);
    chk(lk_data == 32'd0, "R5 miss data", lk_data, 32'd0);
    lk_addr = 32'h44; tick();
    chk(lk_data == 32'd2 && lk_hit, "R5 single match", lk_data, 32'd2);
    lk_addr = 32'h44; st_valid = 1'b1; st_addr = 32'h44; st_data = 32'd7;
    tick();
    st_valid = 1'b0;
    chk(lk_hit == 1'b1, "R7 same-cycle hit", 32'(lk_hit), 32'd1);
    chk(lk_data == 32'd7, "R7 same-cycle data", lk_data, 32'd7);
    take(32'h40, 32'd1, "R2 lookup drain");
    take(32'h44, 32'd2, "R2 lookup drain");
    take(32'h40, 32'd3, "R2 lookup drain");
    take(32'h44, 32'd7, "R2 lookup drain");
    lk_addr = 32'h40; tick();
    chk(lk_hit == 1'b0, "R5 miss after drain", 32'(lk_hit), 32'd0);
    expect_empty("R8 lookup drained");
  endtask

  task automatic t_stray_ack();
    mem_ack = 1'b1;
    repeat (2) tick();
    mem_ack = 1'b0;
    expect_empty("R9 stray ack");
    put(32'h500, 32'h55);
    take(32'h500, 32'h55, "R9 after stray ack");
    expect_empty("R9 final");
  endtask

  initial begin
    t_reset();
    t_single();
    t_full_stall();
    t_full_drain();
    t_lookup();
    t_stray_ack();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule